// File: doc/BRIEF.md
# Inductive Crosstalk Transition Checker

This block decides whether moving one bus segment from its present value to a proposed next value can be done without exceeding inductive noise limits in the package. Every pin's change is scored with a signed three-valued code. Each signal pin is treated as a victim of its neighbours within a fixed coupling reach. The reach may extend into the segments on either side. The sum of the neighbours' codes, weighted by integer coupling coefficients, is then compared against exact integer limits. A quiet pin must not glitch. A switching pin must not be slowed. The supply and ground pins must not bounce because too many signals switch in the same direction.

A segment of `NSEG` pins has a power pin at position 0, a ground pin at position `NSEG-1`, and signal pins in between. Every segment uses this same placement. The caller presents the present and next values of its own signal pins. It also presents the few signal pins of the left and right segments that fall inside the reach. Results are registered: one cycle after the inputs are applied, the block reports one flag per constraint and an overall go/no-go flag. Choosing a replacement vector when a transition is refused is left to the caller.

Top module: `xtalk_legality_chk`

## Requirements
- R1: Each pin's transition is coded +1 when present is 0 and next is 1, -1 when present is 1 and next is 0, and 0 when the value holds. Supply pins and pins outside the given inputs always code 0.
- R2: For signal pin s+1 (bit s of `seg_now`/`seg_next`) holding its value, `rule_viol[3s]` is set exactly when the weighted neighbour sum S = sum over q=1..P_REACH of k_q·(code at distance q below + code at distance q above) is not strictly between -P0 and +P0.
- R3: For signal pin s+1 rising, `rule_viol[3s+1]` is set exactly when S is not greater than P1.
- R4: For signal pin s+1 falling, `rule_viol[3s+2]` is set exactly when S is not less than PM1.
- R5: A neighbour position below pin 0 wraps into the left segment at (position + NSEG), and one above pin NSEG-1 wraps into the right segment at (position − NSEG). Left-segment pin NSEG+1−P_REACH+b is `lnb_*[b]` and right-segment pin b+1 is `rnb_*[b]`.
- R6: `rule_viol[3·NSIG]` (power bounce) is set exactly when Z times the number of rising own signal pins is at least 2·PBNC.
- R7: `rule_viol[3·NSIG+1]` (ground bounce) is set exactly when Z times the number of falling own signal pins is at least 2·PBNC.
- R8: `xfer_legal` is 1 exactly when every bit of `rule_viol` is 0.
- R9: Outputs reflect the inputs present at the previous rising clock edge. While `rst_n` is low, `xfer_legal` is 1 and `rule_viol` is all zeros.
- R10: Of the three flags for any one signal pin, at most one is set at a time. Only the flag matching that pin's own transition can fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_now | input | NSEG-2 | Present values of own signal pins 1..NSEG-2 |
| seg_next | input | NSEG-2 | Proposed values of own signal pins |
| lnb_now | input | P_REACH-2 | Present values of left-segment signal pins within reach |
| lnb_next | input | P_REACH-2 | Proposed values of those left-segment pins |
| rnb_now | input | P_REACH-2 | Present values of right-segment signal pins within reach |
| rnb_next | input | P_REACH-2 | Proposed values of those right-segment pins |
| xfer_legal | output | 1 | 1 when the transition breaks no constraint |
| rule_viol | output | 3·(NSEG-2)+2 | One flag per constraint: three per signal pin, then power, then ground |

## Verification
The only state is the output register, so any fault in the scoring logic shows at the ports on the very next cycle after the offending inputs. Faults of this kind include a wrong code for a pin, a mis-wrapped neighbour, an off-by-one limit or a miscounted supply sum. The fault appears as a wrong flag in `rule_viol`, and usually as a wrong `xfer_legal` too. The bench drives every combination of present and next values on the three own signal pins and the two in-reach neighbour pins. This covers every ternary pattern. The bench compares each result one cycle later against an independent model of the inequalities. A wrapped neighbour that was swapped or dropped therefore shows up on the first pattern where that neighbour's weight moves a sum across a limit.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;

    // Signed ternary transition code
    typedef logic signed [1:0] tcode_t;

    localparam tcode_t TC_HOLD = 2'sb00;
    localparam tcode_t TC_RISE = 2'sb01;
    localparam tcode_t TC_FALL = 2'sb11;

    function automatic tcode_t to_code(input logic now_v, input logic next_v);
        tcode_t c;
        unique case ({now_v, next_v})
            2'b01:   c = TC_RISE;
            2'b10:   c = TC_FALL;
            default: c = TC_HOLD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xt_trans_code.sv
module xt_trans_code
    import xtalk_pkg::*;
(
    input  logic   now_v,
    input  logic   next_v,
    output tcode_t code
);

    always_comb begin
        code = to_code(now_v, next_v);
    end

endmodule

// File: rtl/xt_victim_rule.sv
module xt_victim_rule
    import xtalk_pkg::*;
#(
    parameter int                      P_REACH = 3,
    parameter int                      KW      = 8,
    parameter logic [P_REACH*KW-1:0]   K_PACK  = 24'h01_02_04,
    parameter int                      P0      = 5,
    parameter int                      P1      = -3,
    parameter int                      PM1     = 3
) (
    input  tcode_t               self_code,
    input  tcode_t [P_REACH-1:0] near_lo,
    input  tcode_t [P_REACH-1:0] near_hi,
    output logic   [2:0]         flags
);

    int acc;

    always_comb begin
        acc = 0;
        for (int q = 0; q < P_REACH; q++) begin
            acc += int'($signed(K_PACK[q*KW +: KW])) *
                   (int'(near_lo[q]) + int'(near_hi[q]));
        end
    end

    always_comb begin
        flags    = 3'b000;
        flags[0] = (self_code == TC_HOLD) && !((acc > -P0) && (acc < P0));
        flags[1] = (self_code == TC_RISE) && !(acc > P1);
        flags[2] = (self_code == TC_FALL) && !(acc < PM1);
    end

endmodule

// File: rtl/xt_supply_rule.sv
module xt_supply_rule
    import xtalk_pkg::*;
#(
    parameter int NSIG = 3,
    parameter int Z    = 4,
    parameter int PBNC = 5
) (
    input  tcode_t [NSIG-1:0] codes,
    output logic              pwr_viol,
    output logic              gnd_viol
);

    int n_rise;
    int n_fall;

    always_comb begin
        n_rise = 0;
        n_fall = 0;
        for (int i = 0; i < NSIG; i++) begin
            if (codes[i] == TC_RISE) n_rise++;
            if (codes[i] == TC_FALL) n_fall++;
        end
        pwr_viol = (Z * n_rise) >= (2 * PBNC);
        gnd_viol = (Z * n_fall) >= (2 * PBNC);
    end

endmodule

// File: rtl/xtalk_legality_chk.sv
module xtalk_legality_chk
    import xtalk_pkg::*;
#(
    parameter int                      NSEG    = 5,
    parameter int                      P_REACH = 3,
    parameter int                      KW      = 8,
    parameter logic [P_REACH*KW-1:0]   K_PACK  = 24'h01_02_04,
    parameter int                      P0      = 5,
    parameter int                      P1      = -3,
    parameter int                      PM1     = 3,
    parameter int                      Z       = 4,
    parameter int                      PBNC    = 5,
    localparam int                     NSIG    = NSEG - 2,
    localparam int                     NB      = P_REACH - 2,
    localparam int                     NRULE   = 3*NSIG + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSIG-1:0]  seg_now,
    input  logic [NSIG-1:0]  seg_next,
    input  logic [NB-1:0]    lnb_now,
    input  logic [NB-1:0]    lnb_next,
    input  logic [NB-1:0]    rnb_now,
    input  logic [NB-1:0]    rnb_next,
    output logic             xfer_legal,
    output logic [NRULE-1:0] rule_viol
);

    // Extended window: index e stands for pin position e + 1 - P_REACH
    localparam int NEXT = NSIG + 2*P_REACH;

    tcode_t             ext_code [NEXT];
    tcode_t [NSIG-1:0]  own_code;
    logic   [NRULE-1:0] viol_d;

    // Per-position transition codes, with wrap into neighbour segments
    for (genvar e = 0; e < NEXT; e++) begin : g_pos
        localparam int X = e + 1 - P_REACH;
        if (X >= 1 && X <= NSEG-2) begin : g_own
            xt_trans_code u_code (
                .now_v  (seg_now[X-1]),
                .next_v (seg_next[X-1]),
                .code   (ext_code[e])
            );
        end else if (X == 0 || X == NSEG-1 || X == -1 || X == NSEG) begin : g_supply
            assign ext_code[e] = TC_HOLD;
        end else if (X < 0) begin : g_left
            xt_trans_code u_code (
                .now_v  (lnb_now[X+P_REACH-1]),
                .next_v (lnb_next[X+P_REACH-1]),
                .code   (ext_code[e])
            );
        end else begin : g_right
            xt_trans_code u_code (
                .now_v  (rnb_now[X-NSEG-1]),
                .next_v (rnb_next[X-NSEG-1]),
                .code   (ext_code[e])
            );
        end
    end

    // Victim rules, one per own signal pin
    for (genvar s = 0; s < NSIG; s++) begin : g_vic
        tcode_t [P_REACH-1:0] lo_w;
        tcode_t [P_REACH-1:0] hi_w;

        always_comb begin
            for (int q = 0; q < P_REACH; q++) begin
                lo_w[q] = ext_code[s + P_REACH - 1 - q];
                hi_w[q] = ext_code[s + P_REACH + 1 + q];
            end
        end

        xt_victim_rule #(
            .P_REACH (P_REACH),
            .KW      (KW),
            .K_PACK  (K_PACK),
            .P0      (P0),
            .P1      (P1),
            .PM1     (PM1)
        ) u_vic (
            .self_code (ext_code[s + P_REACH]),
            .near_lo   (lo_w),
            .near_hi   (hi_w),
            .flags     (viol_d[3*s +: 3])
        );
    end

    always_comb begin
        for (int i = 0; i < NSIG; i++) begin
            own_code[i] = ext_code[i + P_REACH];
        end
    end

    xt_supply_rule #(
        .NSIG (NSIG),
        .Z    (Z),
        .PBNC (PBNC)
    ) u_supply (
        .codes    (own_code),
        .pwr_viol (viol_d[3*NSIG]),
        .gnd_viol (viol_d[3*NSIG+1])
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rule_viol  <= '0;
            xfer_legal <= 1'b1;
        end else begin
            rule_viol  <= viol_d;
            xfer_legal <= ~|viol_d;
        end
    end

endmodule

// File: rtl/xtalk_legality_sva.sv
module xtalk_legality_sva #(
    parameter int NSEG    = 5,
    parameter int P_REACH = 3,
    parameter int Z       = 4,
    parameter int PBNC    = 5,
    localparam int NSIG   = NSEG - 2,
    localparam int NB     = P_REACH - 2,
    localparam int NRULE  = 3*NSIG + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSIG-1:0]  seg_now,
    input logic [NSIG-1:0]  seg_next,
    input logic [NB-1:0]    lnb_now,
    input logic [NB-1:0]    lnb_next,
    input logic [NB-1:0]    rnb_now,
    input logic [NB-1:0]    rnb_next,
    input logic             xfer_legal,
    input logic [NRULE-1:0] rule_viol
);

    AST_LEGAL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_legal == (rule_viol == '0));                                          // R8

    AST_QUIET_BUS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_now == seg_next && lnb_now == lnb_next && rnb_now == rnb_next)
        |=> (rule_viol == '0 && xfer_legal));                                      // R9

    AST_PWR_BOUNCE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(seg_next & ~seg_now) * Z >= 2*PBNC) |=> rule_viol[3*NSIG]);    // R6

    AST_PWR_BOUNCE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(seg_next & ~seg_now) * Z < 2*PBNC) |=> !rule_viol[3*NSIG]);    // R6

    AST_GND_BOUNCE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(seg_now & ~seg_next) * Z >= 2*PBNC) |=> rule_viol[3*NSIG+1]);  // R7

    AST_GND_BOUNCE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(seg_now & ~seg_next) * Z < 2*PBNC) |=> !rule_viol[3*NSIG+1]);  // R7

    for (genvar s = 0; s < NSIG; s++) begin : g_pin
        AST_ONE_RULE_PER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rule_viol[3*s +: 3]));                                        // R10

        AST_GLITCH_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_now[s] != seg_next[s]) |=> !rule_viol[3*s]);                      // R2

        AST_RISE_ONLY_RISING: assert property (@(posedge clk) disable iff (!rst_n)
            !(!seg_now[s] && seg_next[s]) |=> !rule_viol[3*s+1]);                  // R3

        AST_FALL_ONLY_FALLING: assert property (@(posedge clk) disable iff (!rst_n)
            !(seg_now[s] && !seg_next[s]) |=> !rule_viol[3*s+2]);                  // R4
    end

endmodule

bind xtalk_legality_chk xtalk_legality_sva #(
    .NSEG    (NSEG),
    .P_REACH (P_REACH),
    .Z       (Z),
    .PBNC    (PBNC)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_now    (seg_now),
    .seg_next   (seg_next),
    .lnb_now    (lnb_now),
    .lnb_next   (lnb_next),
    .rnb_now    (rnb_now),
    .rnb_next   (rnb_next),
    .xfer_legal (xfer_legal),
    .rule_viol  (rule_viol)
);

// File: tb/xtalk_legality_chk_tb.sv
module xtalk_legality_chk_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSIG  = 3;
    localparam int NRULE = 11;
    localparam int K1 = 4, K2 = 2, K3 = 1;
    localparam int LIM_HOLD = 5, LIM_RISE = -3, LIM_FALL = 3;
    localparam int ZV = 4, BNC = 5;

    typedef struct packed {
        logic [NRULE-1:0] viol;
        logic             legal;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSIG-1:0]  seg_now = '0, seg_next = '0;
    logic [0:0]       lnb_now = '0, lnb_next = '0, rnb_now = '0, rnb_next = '0;
    logic             xfer_legal;
    logic [NRULE-1:0] rule_viol;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   drive_done = 1'b0;
    bit   reported   = 1'b0;
    exp_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xtalk_legality_chk u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg_now    (seg_now),
        .seg_next   (seg_next),
        .lnb_now    (lnb_now),
        .lnb_next   (lnb_next),
        .rnb_now    (rnb_now),
        .rnb_next   (rnb_next),
        .xfer_legal (xfer_legal),
        .rule_viol  (rule_viol)
    );

    // Ternary code per R1
    function automatic int tcode(input logic a, input logic b);
        if (!a && b) return 1;
        if (a && !b) return -1;
        return 0;
    endfunction

    // Independent model of R1..R8, pin position x stored at t[x+2]
    function automatic exp_t model(input logic [4:0] cur, input logic [4:0] nxt);
        int   t [9];
        int   kk [4];
        int   sum, code, rise, fall;
        exp_t r;
        kk[1] = K1; kk[2] = K2; kk[3] = K3;
        for (int i = 0; i < 9; i++) t[i] = 0;
        t[0] = tcode(cur[3], nxt[3]);          // left segment pin 3 (R5)
        for (int i = 0; i < 3; i++) t[3+i] = tcode(cur[i], nxt[i]);
        t[8] = tcode(cur[4], nxt[4]);          // right segment pin 1 (R5)
        r.viol = '0;
        rise = 0; fall = 0;
        for (int s = 0; s < 3; s++) begin
            code = t[3+s];
            sum  = 0;
            for (int q = 1; q <= 3; q++) sum += kk[q] * (t[3+s-q] + t[3+s+q]);
            if (code == 0 && !(sum > -LIM_HOLD && sum < LIM_HOLD)) r.viol[3*s]   = 1'b1;
            if (code == 1 && !(sum > LIM_RISE))                    r.viol[3*s+1] = 1'b1;
            if (code == -1 && !(sum < LIM_FALL))                   r.viol[3*s+2] = 1'b1;
            if (code == 1)  rise++;
            if (code == -1) fall++;
        end
        r.viol[9]  = (ZV * rise >= 2*BNC);
        r.viol[10] = (ZV * fall >= 2*BNC);
        r.legal    = (r.viol == '0);
        return r;
    endfunction

    function automatic string tag_of(input int bitpos);
        if (bitpos == 9)  return "R6";
        if (bitpos == 10) return "R7";
        case (bitpos % 3)
            0:       return "R2";
            1:       return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: applies vectors on the falling edge and queues expected results
    task automatic drive(input logic [4:0] cur, input logic [4:0] nxt);
        @(negedge clk);
        seg_now  = cur[2:0];  seg_next = nxt[2:0];
        lnb_now  = cur[3];    lnb_next = nxt[3];
        rnb_now  = cur[4];    rnb_next = nxt[4];
        exp_q.push_back(model(cur, nxt));
    endtask

    // Monitor: one cycle latency per R9, sampled after the edge
    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if (rule_viol !== e.viol) begin
                    n_fail++;
                    for (int b = 0; b < NRULE; b++) begin
                        if (rule_viol[b] !== e.viol[b]) begin
                            $display("FAIL %s (R1 R5 R10 sweep) in=%b/%b bit %0d: actual %b expected %b",
                                     tag_of(b), {rnb_now, lnb_now, seg_now},
                                     {rnb_next, lnb_next, seg_next}, b, rule_viol, e.viol);
                            break;
                        end
                    end
                end
                n_checks++;
                if (xfer_legal !== e.legal) begin
                    n_fail++;
                    $display("FAIL R8 legal flag: actual %b expected %b", xfer_legal, e.legal);
                end
            end
        end
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        n_checks++;
        if (xfer_legal !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 reset legal: actual %b expected 1", xfer_legal);
        end
        n_checks++;
        if (rule_viol !== '0) begin
            n_fail++;
            $display("FAIL R9 reset flags: actual %b expected %b", rule_viol, {NRULE{1'b0}});
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        // Full sweep of every present/next combination (all ternary patterns)
        for (int c = 0; c < 32; c++) begin
            for (int n = 0; n < 32; n++) begin
                drive(5'(c), 5'(n));
            end
        end
        // Directed: all own pins rise (R6) then all fall (R7), then hold (R9)
        drive(5'b00000, 5'b00111);
        drive(5'b00111, 5'b00000);
        drive(5'b10101, 5'b10101);
        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        drive_done = 1'b1;
        summary();
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!drive_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog expired: actual hung expected completion");
        end
        summary();
    end

endmodule